// File: doc/BRIEF.md
# Downward-Growing Hardware Stack

This block is a small last-in-first-out store built from a register array and a stack pointer. After reset the pointer rests at the top of the storage region, one place above the highest word. Each accepted push moves the pointer down by one and writes the incoming word at the new position. Each accepted pop reads the word at the current position and moves the pointer back up by one. Words therefore leave in the reverse of the order in which they arrived.

The block sits beside a datapath that needs short-term nesting storage, such as return values or nested contexts. It has one push strobe, one pop strobe, a write word and a registered read word, plus full and empty flags. A push with the stack full, or a pop with the stack empty, is refused and sets an error flag. That flag stays set until reset. A push and a pop in the same cycle exchange the top word for the new one in a single clock.

Top module: `down_stack`

## Requirements
- R1: During and after reset, `empty` is 1, `full` is 0, `err` is 0 and `rd_data` is 0.
- R2: Words come back in the reverse of their entry order; pushing 0x0D, 0x0C, 0x0B, 0x0A and then popping four times yields 0x0A, 0x0B, 0x0C, 0x0D.
- R3: Each accepted push (push_req=1, pop_req=0, not full) lowers the pointer by one; `empty` drops after the first push and `full` is 1 once DEPTH words are held.
- R4: A popped word appears on `rd_data` on the clock edge that accepts the pop; `rd_data` holds its value in every cycle without an accepted read.
- R5: `empty` returns to 1 once every stored word has been popped, and `full` and `empty` are never 1 together.
- R6: A push alone while `full` is 1 is refused: the pointer and the stored words stay unchanged, and `err` becomes 1.
- R7: A pop alone while `empty` is 1 is refused: the pointer and `rd_data` stay unchanged, and `err` becomes 1.
- R8: Once set, `err` stays 1 through later legal traffic and idle cycles, and only reset clears it.
- R9: push_req=1 together with pop_req=1 while not empty puts the old top word on `rd_data`, stores `wr_data` in its place and leaves the depth unchanged, including when full.
- R10: push_req=1 together with pop_req=1 while empty is refused as an underflow: nothing is stored, `empty` stays 1 and `err` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to store `wr_data` on top |
| pop_req | input | 1 | Request to remove the top word |
| wr_data | input | WIDTH | Word to be stored |
| rd_data | output | WIDTH | Last word read from the top (registered) |
| full | output | 1 | All DEPTH places occupied |
| empty | output | 1 | No word stored |
| err | output | 1 | Sticky refused-request indicator |

## Verification
The bench builds the stack with WIDTH=8 and DEPTH=4. This small depth reaches the full boundary after four pushes, so the overflow refusal, the exchange on a full stack and a complete drain all fit into short directed scenarios. The reversal check with four distinct words covers every storage place. The refusal cases are then observed through `rd_data` and by draining the stack afterwards.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP,
    OP_BAD
  } stack_op_e;
endpackage

// File: rtl/stack_ptr_ctrl.sv
module stack_ptr_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic             full_q, empty_q, err_q;
  stack_op_e        op;

  always_comb begin
    if (push_i && pop_i)  op = empty_q ? OP_BAD : OP_SWAP;
    else if (push_i)      op = full_q  ? OP_BAD : OP_PUSH;
    else if (pop_i)       op = empty_q ? OP_BAD : OP_POP;
    else                  op = OP_IDLE;
  end

  always_comb begin
    ptr_nxt   = ptr_q;
    wr_en_o   = 1'b0;
    rd_en_o   = 1'b0;
    wr_addr_o = ptr_q[ADDR_W-1:0];
    rd_addr_o = ptr_q[ADDR_W-1:0];
    case (op)
      OP_PUSH: begin
        ptr_nxt   = ptr_q - ONE;
        wr_en_o   = 1'b1;
        wr_addr_o = ptr_nxt[ADDR_W-1:0];
      end
      OP_POP: begin
        ptr_nxt = ptr_q + ONE;
        rd_en_o = 1'b1;
      end
      OP_SWAP: begin
        wr_en_o = 1'b1;
        rd_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= TOP;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_nxt;
      full_q  <= (ptr_nxt == '0);
      empty_q <= (ptr_nxt == TOP);
      err_q   <= err_q | (op == OP_BAD);
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign err_o   = err_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && full_q) |=> ($stable(ptr_q) && err_q));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty_q) |=> ($stable(ptr_q) && err_q));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && !full_q) |=> (ptr_q == $past(ptr_q) - ONE));

  // R9
  swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !empty_q) |=> $stable(ptr_q));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q));

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= TOP);
endmodule

// File: rtl/stack_store.sv
module stack_store #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/down_stack.sv
module down_stack #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic             err
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PTR_W  = $clog2(DEPTH + 1);

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  stack_ptr_ctrl #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .PTR_W (PTR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_i   (push_req),
    .pop_i    (pop_req),
    .full_o   (full),
    .empty_o  (empty),
    .err_o    (err),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .rd_en_o  (rd_en),
    .rd_addr_o(rd_addr)
  );

  stack_store #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (empty && !full && !err && rd_data == '0));
endmodule

// File: tb/test_down_stack.sv
`timescale 1ns/1ps
module test_down_stack;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push_req = 1'b0;
  logic         pop_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         full, empty, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  down_stack #(.WIDTH(W), .DEPTH(D)) i_down_stack (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .wr_data(wr_data), .rd_data(rd_data), .full(full), .empty(empty), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit q, input logic [W-1:0] d);
    push_req = p; pop_req = q; wr_data = d;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic t_order();
    do_reset();
    step(1, 0, 8'h0D);
    chk("R3 empty after first push", int'(empty), 0);
    step(1, 0, 8'h0C);
    step(1, 0, 8'h0B);
    chk("R3 not full at D-1", int'(full), 0);
    step(1, 0, 8'h0A);
    chk("R3 full at D", int'(full), 1);
    for (int i = 0; i < D; i++) begin
      step(0, 1, '0);
      chk("R2 reverse order", int'(rd_data), 8'h0A + i);
    end
    chk("R5 empty after drain", int'(empty), 1);
    chk("R5 full after drain", int'(full), 0);
    step(0, 0, 8'h99);
    step(0, 0, 8'h98);
    chk("R4 rd_data holds", int'(rd_data), 8'h0D);
    chk("R6 no error on legal use", int'(err), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < D; i++) step(1, 0, 8'h40 + i);
    step(1, 0, 8'hEE);
    chk("R6 err on overflow", int'(err), 1);
    chk("R6 still full", int'(full), 1);
    for (int i = 0; i < D; i++) begin
      step(0, 1, '0);
      chk("R6 contents kept", int'(rd_data), 8'h40 + D - 1 - i);
    end
    chk("R6 depth kept", int'(empty), 1);
  endtask

  task automatic t_underflow();
    do_reset();
    step(1, 0, 8'h5A);
    step(0, 1, '0);
    chk("R4 pop data", int'(rd_data), 8'h5A);
    step(0, 1, '0);
    chk("R7 rd_data unchanged", int'(rd_data), 8'h5A);
    chk("R7 err on underflow", int'(err), 1);
    chk("R7 still empty", int'(empty), 1);
    step(1, 0, 8'h21);
    chk("R7 pointer kept", int'(empty), 0);
    step(0, 1, '0);
    chk("R7 next pop correct", int'(rd_data), 8'h21);
    step(0, 0, '0);
    step(0, 0, '0);
    chk("R8 err sticky", int'(err), 1);
    do_reset();
    chk("R8 reset clears err", int'(err), 0);
  endtask

  task automatic t_swap();
    do_reset();
    step(1, 0, 8'h11);
    step(1, 0, 8'h22);
    step(1, 1, 8'h33);
    chk("R9 old top out", int'(rd_data), 8'h22);
    chk("R9 no error", int'(err), 0);
    step(0, 1, '0);
    chk("R9 replaced top", int'(rd_data), 8'h33);
    step(0, 1, '0);
    chk("R9 lower word", int'(rd_data), 8'h11);
    chk("R9 depth unchanged", int'(empty), 1);
    for (int i = 0; i < D; i++) step(1, 0, 8'h60 + i);
    step(1, 1, 8'h77);
    chk("R9 swap when full", int'(rd_data), 8'h60 + D - 1);
    chk("R9 full kept", int'(full), 1);
    chk("R9 no error when full", int'(err), 0);
    step(0, 1, '0);
    chk("R9 full swap stored", int'(rd_data), 8'h77);
  endtask

  task automatic t_swap_empty();
    do_reset();
    step(1, 1, 8'h44);
    chk("R10 err", int'(err), 1);
    chk("R10 empty kept", int'(empty), 1);
    chk("R10 rd_data unchanged", int'(rd_data), 0);
    step(1, 0, 8'h55);
    step(0, 1, '0);
    chk("R10 nothing stored", int'(rd_data), 8'h55);
    chk("R10 empty again", int'(empty), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_overflow();
    t_underflow();
    t_swap();
    t_swap_empty();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule